// File: doc/BRIEF.md
# Selectable Clock Output Divider

This block drives three clock outputs from two oscillator inputs. Output A is derived from oscillator 1. Outputs B and C are derived from oscillator 0, which is normally a 33.8688 MHz reference. Each output has its own 3-bit select input. The select picks a division ratio or stops the output. A microcontroller register normally drives the selects, and here they appear as plain input ports. A select can change at any moment and in any clock domain.

Each output has its own channel. A channel first synchronizes its select into its source clock. It then runs a counter sized for the longest ratio and shapes the output from registered phase bits. Divide by 5 uses a falling-edge register, which stretches the high phase by half a source cycle and gives a 50% duty cycle. A new ratio is loaded only at the end of the current output period. Every pattern starts with its low phase, so no runt pulse appears.

Oscillator 1 may be absent, with its pin tied low. Reset clears every channel asynchronously, so output A sits low even though it has no clock edges. Reset is released synchronously to each channel's own clock.

Top module: `ckdiv_top`

## Requirements
- R1: While reset is high, and afterwards until a non-stop select is applied, all three outputs are low.
- R2: Output A follows oscillator 1 with select 001, giving the same period. With select 010 it runs at oscillator 1 divided by 2, high for exactly one source period.
- R3: Output B gives oscillator 0 divided by 1 (select 001), 2 (010), 5 (011) or 512 (100). Divide by 512 is high for 256 source cycles.
- R4: In divide-by-5 mode the output is high for 2.5 source cycles and low for 2.5 source cycles.
- R5: Output C with select 101 gives two output cycles per five source cycles. Consecutive rising edges are 2 and 3 source cycles apart, alternating, and each high phase lasts one source cycle.
- R6: Output C gives oscillator 0 divided by 1 (001), 5 (011) or 512 (100).
- R7: Select 000 stops an output low. Codes an output does not support also act as stop and hold it low: 011, 100, 101, 110 and 111 on A; 101, 110 and 111 on B; 010, 110 and 111 on C.
- R8: A ratio change produces no high or low phase shorter than the shorter half-period of the old and new ratios.
- R9: An output that restarts from stop begins with a full low phase. From stop into divide by 512, the first rising edge comes at least 256 source cycles after the select changes.
- R10: With oscillator 1 held low, reset still clears output A. Output A then stays low whatever its select, while output B keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc0 | input | 1 | Main reference oscillator, source of outputs B and C |
| clk_osc1 | input | 1 | Second oscillator, source of output A; may be tied low |
| rst | input | 1 | Active-high chip reset; asserts asynchronously, releases per clock domain |
| sel_a | input | 3 | Ratio select for output A |
| sel_b | input | 3 | Ratio select for output B |
| sel_c | input | 3 | Ratio select for output C |
| ck_a | output | 1 | Divided clock A |
| ck_b | output | 1 | Divided clock B |
| ck_c | output | 1 | Divided clock C |

## Verification
The hardest case to reach from the ports is a ratio change that lands in the middle of a long period. A glitch shows up only as one short phase, somewhere inside a window of several hundred source cycles. The bench starts output B in divide by 512 and switches it to divide by 2. It starts output C in divide by 1 and switches it to divide by 5. For each switch, it samples the output on a 1 ns grid across the whole window and records the narrowest high and low phase it sees. The restart case is measured the same way, from the moment the select changes until the first rising edge.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

  // Select codes double as the internal mode encoding.
  typedef enum logic [2:0] {
    MODE_STOP = 3'd0,
    MODE_DIV1 = 3'd1,
    MODE_DIV2 = 3'd2,
    MODE_DIV5 = 3'd3,
    MODE_DIVL = 3'd4,
    MODE_R25  = 3'd5
  } mode_e;

  // One bit per select code; a set bit means the channel supports it.
  localparam logic [7:0] ALLOW_A = 8'h07; // stop, /1, /2
  localparam logic [7:0] ALLOW_B = 8'h1F; // stop, /1, /2, /5, /long
  localparam logic [7:0] ALLOW_C = 8'h3B; // stop, /1, /5, /long, 2/5

endpackage

// File: rtl/ckdiv_rst_sync.sv
module ckdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  output logic rst_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_q = chain[STAGES-1];
endmodule

// File: rtl/ckdiv_sel_sync.sv
module ckdiv_sel_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or posedge rst_q) begin
    if (rst_q) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ckdiv_channel.sv
module ckdiv_channel
  import ckdiv_pkg::*;
#(
  parameter logic [7:0] ALLOW       = 8'h1F,
  parameter int         LONG_DIV    = 512,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_in,
  output logic       ck_out
);
  localparam int             CW     = $clog2(LONG_DIV);
  localparam logic [CW-1:0]  L_LONG = CW'(LONG_DIV - 1);
  localparam logic [CW-1:0]  L_HALF = CW'(LONG_DIV / 2);
  localparam logic [CW-1:0]  L_ONE  = CW'(1);
  localparam logic [CW-1:0]  L_TWO  = CW'(2);
  localparam logic [CW-1:0]  L_THR  = CW'(3);
  localparam logic [CW-1:0]  L_FOUR = CW'(4);

  logic          rst_q;
  logic [2:0]    sel_s;
  mode_e         req, cur, nxt_mode;
  logic [CW-1:0] cnt, nxt_cnt;
  logic          at_end;
  logic          p, n, g;

  ckdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst(rst), .rst_q(rst_q)
  );

  ckdiv_sel_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sel (
    .clk(clk), .rst_q(rst_q), .d(sel_in), .q(sel_s)
  );

  // Last count value of a period in each mode.
  function automatic logic [CW-1:0] last_of(mode_e m);
    case (m)
      MODE_DIV2: last_of = L_ONE;
      MODE_DIV5: last_of = L_FOUR;
      MODE_R25:  last_of = L_FOUR;
      MODE_DIVL: last_of = L_LONG;
      default:   last_of = '0;
    endcase
  endfunction

  // Posedge-registered output phase; count 0 is always low.
  function automatic logic phase_of(mode_e m, logic [CW-1:0] c);
    case (m)
      MODE_DIV2: phase_of = (c == L_ONE);
      MODE_DIV5: phase_of = (c == L_TWO) || (c == L_THR);
      MODE_DIVL: phase_of = (c >= L_HALF);
      MODE_R25:  phase_of = (c == L_ONE) || (c == L_THR);
      default:   phase_of = 1'b0;
    endcase
  endfunction

  always_comb begin
    req = ALLOW[sel_s] ? mode_e'(sel_s) : MODE_STOP;
  end

  assign at_end = (cnt == last_of(cur));

  always_comb begin
    nxt_mode = cur;
    nxt_cnt  = cnt + L_ONE;
    if (at_end) begin
      nxt_cnt  = '0;
      nxt_mode = req;
    end
  end

  always_ff @(posedge clk or posedge rst_q) begin
    if (rst_q) begin
      cur <= MODE_STOP;
      cnt <= '0;
      p   <= 1'b0;
    end else begin
      cur <= nxt_mode;
      cnt <= nxt_cnt;
      p   <= phase_of(nxt_mode, nxt_cnt);
    end
  end

  // Falling-edge stage: half-cycle stretch for /5 and gate for /1.
  always_ff @(negedge clk or posedge rst_q) begin
    if (rst_q) begin
      n <= 1'b0;
      g <= 1'b0;
    end else begin
      n <= p && (cur == MODE_DIV5);
      g <= (cur == MODE_DIV1);
    end
  end

  assign ck_out = (clk & g) | p | n;

  // R7
  legal_mode_chk: assert property (@(posedge clk) disable iff (rst_q)
    ALLOW[cur]);

  // R8
  switch_at_end_chk: assert property (@(posedge clk) disable iff (rst_q)
    (cur != $past(cur)) |-> (($past(cnt) == last_of($past(cur))) && (cnt == '0) && !p));

  // R7
  stop_low_chk: assert property (@(posedge clk) disable iff (rst_q)
    ((cur == MODE_STOP) && ($past(cur) == MODE_STOP)) |-> (!p && !n && !g));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst_q)
    cnt <= last_of(cur));

  // R4
  half_phase_chk: assert property (@(posedge clk) disable iff (rst_q)
    n |-> ((cur == MODE_DIV5) || ($past(cur) == MODE_DIV5)));

endmodule

// File: rtl/ckdiv_top.sv
module ckdiv_top
  import ckdiv_pkg::*;
#(
  parameter int LONG_DIV    = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_osc0,
  input  logic       clk_osc1,
  input  logic       rst,
  input  logic [2:0] sel_a,
  input  logic [2:0] sel_b,
  input  logic [2:0] sel_c,
  output logic       ck_a,
  output logic       ck_b,
  output logic       ck_c
);
  localparam int         NCH = 3;
  localparam logic [7:0] ALLOW_TBL [NCH] = '{ALLOW_A, ALLOW_B, ALLOW_C};

  logic [NCH-1:0] clk_v;
  logic [2:0]     sel_v [NCH];
  logic [NCH-1:0] ck_v;

  assign clk_v    = {clk_osc0, clk_osc0, clk_osc1};
  assign sel_v[0] = sel_a;
  assign sel_v[1] = sel_b;
  assign sel_v[2] = sel_c;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ckdiv_channel #(
      .ALLOW(ALLOW_TBL[i]),
      .LONG_DIV(LONG_DIV),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_ch (
      .clk(clk_v[i]),
      .rst(rst),
      .sel_in(sel_v[i]),
      .ck_out(ck_v[i])
    );
  end

  assign ck_a = ck_v[0];
  assign ck_b = ck_v[1];
  assign ck_c = ck_v[2];
endmodule

// File: tb/ckdiv_top_tb_top.sv
`timescale 1ns/100ps
module ckdiv_top_tb_top;
  logic clk_osc0 = 1'b0;
  logic clk_osc1 = 1'b0;
  logic osc1_en  = 1'b1;
  logic rst      = 1'b1;
  logic [2:0] sel_a = 3'd0, sel_b = 3'd0, sel_c = 3'd0;
  logic ck_a, ck_b, ck_c;

  int n_chk  = 0;
  int n_fail = 0;
  int now_ns = 0;

  ckdiv_top dut_i (
    .clk_osc0(clk_osc0), .clk_osc1(clk_osc1), .rst(rst),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .ck_a(ck_a), .ck_b(ck_b), .ck_c(ck_c)
  );

  always #10 clk_osc0 = ~clk_osc0;
  always begin
    #15;
    clk_osc1 = osc1_en ? ~clk_osc1 : 1'b0;
  end

  function automatic logic outv(int w);
    case (w)
      0: outv = ck_a;
      1: outv = ck_b;
      default: outv = ck_c;
    endcase
  endfunction

  task automatic step();
    #1;
    now_ns++;
  endtask

  task automatic wait_ns(int ns);
    for (int i = 0; i < ns; i++) step();
  endtask

  task automatic set_sel(int w, logic [2:0] code);
    case (w)
      0: sel_a = code;
      1: sel_b = code;
      default: sel_c = code;
    endcase
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_range(string req, string what, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic capture(int w, int limit, output int r0, output int r1, output int r2,
                         output int f0, output int f1, output bit ok);
    int   nr = 0;
    int   nf = 0;
    logic prev, curv;
    r0 = 0; r1 = 0; r2 = 0; f0 = 0; f1 = 0;
    prev = outv(w);
    for (int i = 0; i < limit && nr < 3; i++) begin
      step();
      curv = outv(w);
      if (!prev && curv) begin
        if (nr == 0) r0 = now_ns;
        else if (nr == 1) r1 = now_ns;
        else r2 = now_ns;
        nr++;
      end
      if (prev && !curv && nr >= 1 && nf < 2) begin
        if (nf == 0) f0 = now_ns;
        else f1 = now_ns;
        nf++;
      end
      prev = curv;
    end
    ok = (nr == 3) && (nf == 2);
  endtask

  task automatic run_ratio(string req, int w, logic [2:0] code, int per, int hi);
    int r0, r1, r2, f0, f1;
    bit ok;
    set_sel(w, code);
    wait_ns(12000);
    capture(w, 4 * per + 100, r0, r1, r2, f0, f1, ok);
    chk(req, $sformatf("out%0d code%0d edges seen", w, code), int'(ok), 1);
    chk(req, $sformatf("out%0d code%0d period", w, code), r1 - r0, per);
    chk(req, $sformatf("out%0d code%0d period2", w, code), r2 - r1, per);
    chk(req, $sformatf("out%0d code%0d high", w, code), f0 - r0, hi);
  endtask

  task automatic count_high(int w, int ns, output int highs);
    highs = 0;
    for (int i = 0; i < ns; i++) begin
      step();
      if (outv(w)) highs++;
    end
  endtask

  task automatic min_widths(int w, int ns, output int minh, output int minl);
    logic prev, curv;
    int   last = -1;
    minh = 1 << 30;
    minl = 1 << 30;
    prev = outv(w);
    for (int i = 0; i < ns; i++) begin
      step();
      curv = outv(w);
      if (curv != prev) begin
        if (last >= 0) begin
          if (prev && (now_ns - last) < minh) minh = now_ns - last;
          if (!prev && (now_ns - last) < minl) minl = now_ns - last;
        end
        last = now_ns;
      end
      prev = curv;
    end
  endtask

  task automatic t_reset();
    wait_ns(200);
    chk("R1", "ck_a during reset", int'(ck_a), 0);
    chk("R1", "ck_b during reset", int'(ck_b), 0);
    chk("R1", "ck_c during reset", int'(ck_c), 0);
    rst = 1'b0;
    wait_ns(500);
    chk("R1", "outputs after reset, select stop", int'({ck_a, ck_b, ck_c}), 0);
  endtask

  task automatic t_out_a();
    run_ratio("R2", 0, 3'b001, 30, 15);
    run_ratio("R2", 0, 3'b010, 60, 30);
  endtask

  task automatic t_out_b();
    run_ratio("R3", 1, 3'b001, 20, 10);
    run_ratio("R3", 1, 3'b010, 40, 20);
    run_ratio("R4", 1, 3'b011, 100, 50);
    run_ratio("R3", 1, 3'b100, 10240, 5120);
  endtask

  task automatic t_out_c();
    run_ratio("R6", 2, 3'b001, 20, 10);
    run_ratio("R4", 2, 3'b011, 100, 50);
    run_ratio("R6", 2, 3'b100, 10240, 5120);
  endtask

  task automatic t_rate25();
    int r0, r1, r2, f0, f1;
    bit ok;
    set_sel(2, 3'b101);
    wait_ns(12000);
    capture(2, 400, r0, r1, r2, f0, f1, ok);
    chk("R5", "2/5 edges seen", int'(ok), 1);
    chk("R5", "2/5 two periods span", r2 - r0, 100);
    chk("R5", "2/5 uneven periods", int'(((r1 - r0) == 40) || ((r1 - r0) == 60)), 1);
    chk("R5", "2/5 first high", f0 - r0, 20);
    chk("R5", "2/5 second high", f1 - r1, 20);
  endtask

  task automatic t_illegal();
    int h;
    set_sel(0, 3'b011); set_sel(1, 3'b101); set_sel(2, 3'b010);
    wait_ns(12000);
    count_high(0, 2000, h); chk("R7", "A code 011 acts as stop", h, 0);
    count_high(1, 2000, h); chk("R7", "B code 101 acts as stop", h, 0);
    count_high(2, 2000, h); chk("R7", "C code 010 acts as stop", h, 0);
    set_sel(0, 3'b010); set_sel(2, 3'b001); wait_ns(12000);
    set_sel(0, 3'b111); set_sel(2, 3'b110);
    wait_ns(12000);
    count_high(0, 2000, h); chk("R7", "A code 111 acts as stop", h, 0);
    count_high(2, 2000, h); chk("R7", "C code 110 acts as stop", h, 0);
  endtask

  task automatic t_stop();
    int h;
    set_sel(1, 3'b010); wait_ns(12000);
    set_sel(1, 3'b000); wait_ns(12000);
    count_high(1, 3000, h);
    chk("R7", "B stopped holds low", h, 0);
  endtask

  task automatic t_switch();
    int mh, ml;
    set_sel(1, 3'b100); wait_ns(12000);
    wait_ns(3000);
    set_sel(1, 3'b010);
    min_widths(1, 12000, mh, ml);
    chk_range("R8", "B /512->/2 narrowest high", mh, 20, 1 << 30);
    chk_range("R8", "B /512->/2 narrowest low", ml, 20, 1 << 30);
    set_sel(2, 3'b001); wait_ns(12000);
    set_sel(2, 3'b011);
    min_widths(2, 2000, mh, ml);
    chk_range("R8", "C /1->/5 narrowest high", mh, 10, 1 << 30);
    chk_range("R8", "C /1->/5 narrowest low", ml, 10, 1 << 30);
  endtask

  task automatic t_restart();
    int r0, r1, r2, f0, f1, t0;
    bit ok;
    set_sel(1, 3'b000); wait_ns(12000);
    t0 = now_ns;
    set_sel(1, 3'b100);
    capture(1, 40000, r0, r1, r2, f0, f1, ok);
    chk_range("R9", "B first rise after restart", r0 - t0, 5120, 5200);
  endtask

  task automatic t_osc1_absent();
    int h;
    set_sel(0, 3'b010); set_sel(1, 3'b010);
    wait_ns(5000);
    osc1_en = 1'b0;
    wait_ns(100);
    rst = 1'b1;
    wait_ns(200);
    rst = 1'b0;
    wait_ns(2000);
    count_high(0, 3000, h);
    chk("R10", "A low with osc1 absent", h, 0);
    run_ratio("R10", 1, 3'b010, 40, 20);
  endtask

  initial begin
    #0.5;
    t_reset();
    t_out_a();
    t_out_b();
    t_out_c();
    t_rate25();
    t_illegal();
    t_stop();
    t_switch();
    t_restart();
    t_osc1_absent();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", now_ns, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule